// File: doc/BRIEF.md
# Module Control Register Bank

This block is a small bank of 16-bit registers on a synchronous host bus. The host presents a request with an address, a write flag and write data. Any address whose upper bits match the bank's base page is acknowledged, and the low eight address bits select a word. The bank holds:

- an identity word, built from a firmware constant and the board's serial-number jumpers;
- a revision word;
- a status word, showing configuration-done, timing-ready and clock-lock inputs after synchronization;
- a read/write mode word, whose outputs drive board-level selects;
- a write-one pulse word, which issues single-cycle reset and command strobes to the rest of the board.

Bus rules: a request is one cycle of `host_req` high. The acknowledge follows in the next cycle for every address inside the window. Nothing is acknowledged outside the window. The host must not present a request in the cycle its acknowledge is high, so each acknowledge is a single-cycle pulse. No back-pressure exists: every in-window request is accepted in the cycle it is presented. `host_rdata` changes only when an in-window read is accepted and holds that value until the next one.

Two fields carry special rules. At power-up, the mode word's geographic-bypass field loads from the geographic-address pins. The mode word's clock-select bit can only be raised while the timing receiver reports ready.

Top module: `ctlbank_top`

## Requirements
- R1: During and right after reset, `strobe_o` is 0 and `host_ack` is 0. `mode_o` equals the geographic pins placed in bits 4:1, with every other bit 0.
- R2: An in-window request is acknowledged in the cycle after it is presented, whatever its offset. The window is `host_addr[23:8]` equal to 16'h7000. A request outside the window is never acknowledged.
- R3: Word offsets (byte addresses) are read as follows:
  - 0x00 reads {3'b101, serial pins, 8'h5C};
  - 0x02 reads 16'h1102;
  - 0x08 reads status, with `cfg_done[1:0]` at bits 6:5, `rx_ready` at bit 7 and `pll_lock[1:0]` at bits 9:8;
  - every undecoded even offset reads 0.
- R4: The mode word (offset 0x04) stores only the defined bits, mask 16'h3E7E. Undefined bits always read 0.
- R5: A write cannot raise mode bit 5 (clock select) while the synchronized `rx_ready` is low; the bit keeps its old value. Clearing it, or keeping it set, is always allowed.
- R6: Mode bits 4:1 take the geographic pins only at reset. Later pin changes have no effect, and host writes may change the field.
- R7: Writing to the pulse word (offset 0x06) raises `strobe_o` for exactly one cycle, with the written bits under mask 16'h0F7F. That cycle is the one in which `host_ack` is high. Bit 9 is clear-errors and bit 11 is counter-reset. Writing 0 raises nothing, and undefined bits never strobe.
- R8: The pulse word always reads 0.
- R9: `strobe_n_o` is the bitwise inverse of `strobe_o` in every cycle.
- R10: Writes to the identity, revision and status words, and to undecoded offsets, change no readable state.
- R11: A status-input change appears in reads issued three or more cycles later.
- R12: `host_rdata` keeps its value across writes and idle cycles until the next in-window read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 24 | Byte address |
| host_wdata | input | 16 | Write data |
| host_ack | output | 1 | Acknowledge, one cycle after an in-window request |
| host_rdata | output | 16 | Read data, held until the next read |
| geo_addr | input | 4 | Geographic address pins, loaded at reset |
| serial_pins | input | 5 | Serial-number jumpers |
| cfg_done | input | 2 | Configuration-done flags |
| rx_ready | input | 1 | Timing receiver ready |
| pll_lock | input | 2 | Clock-lock flags |
| mode_o | output | 16 | Mode word contents |
| strobe_o | output | 16 | Single-cycle command strobes |
| strobe_n_o | output | 16 | Active-low copies of the strobes |

## Verification
The bench sweeps every even offset of the window, and every single-bit and several multi-bit write patterns on the mode and pulse words. Each readback is checked against masks computed in the bench.

A decoder that ignored the page bits would acknowledge foreign addresses. A mode word without its gate would raise clock select while the receiver is down. A mode word that sampled the pins after reset would lose host writes to the bypass field.

A pulse word that stored its value would read back non-zero or hold strobes for more than one cycle. Missing masks would leak undefined bits. Read data driven on writes would break the hold rule.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_REV,
    SEL_MODE,
    SEL_PULSE,
    SEL_STAT
  } sel_e;

  // word index = byte offset / 2
  localparam logic [6:0] WORD_ID    = 7'd0;
  localparam logic [6:0] WORD_REV   = 7'd1;
  localparam logic [6:0] WORD_MODE  = 7'd2;
  localparam logic [6:0] WORD_PULSE = 7'd3;
  localparam logic [6:0] WORD_STAT  = 7'd4;

  localparam logic [15:0] MODE_MASK  = 16'h3E7E;
  localparam logic [15:0] PULSE_MASK = 16'h0F7F;
  localparam int          CLKSEL_BIT = 5;

endpackage

// File: rtl/ctlbank_sync.sv
module ctlbank_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[g];
        s2 <= s1;
      end
    end
    assign q[g] = s2;
  end
endmodule

// File: rtl/ctlbank_decode.sv
module ctlbank_decode
  import ctlbank_pkg::*;
#(
  parameter int                ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE   = 24'h700000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output sel_e              sel
);
  localparam int PAGE_W = ADDR_W - 8;
  localparam logic [PAGE_W-1:0] PAGE = BASE[ADDR_W-1:8];

  logic [6:0] word;

  assign in_win = (addr[ADDR_W-1:8] == PAGE);
  assign word   = addr[7:1];

  always_comb begin
    unique case (word)
      WORD_ID:    sel = SEL_ID;
      WORD_REV:   sel = SEL_REV;
      WORD_MODE:  sel = SEL_MODE;
      WORD_PULSE: sel = SEL_PULSE;
      WORD_STAT:  sel = SEL_STAT;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/ctlbank_pulse.sv
module ctlbank_pulse #(
  parameter int          W    = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] strobe,
  output logic [W-1:0] strobe_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= '0;
    else        strobe <= fire ? (wdata & MASK) : '0;
  end

  assign strobe_n = ~strobe;
endmodule

// File: rtl/ctlbank_top.sv
module ctlbank_top
  import ctlbank_pkg::*;
#(
  parameter int                ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE   = 24'h700000,
  parameter logic [7:0]        FW_ID  = 8'h5C,
  parameter logic [2:0]        SN_HI  = 3'b101,
  parameter logic [7:0]        HW_REV = 8'h02,
  parameter logic [7:0]        FW_REV = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  output logic              host_ack,
  output logic [15:0]       host_rdata,
  input  logic [3:0]        geo_addr,
  input  logic [4:0]        serial_pins,
  input  logic [1:0]        cfg_done,
  input  logic              rx_ready,
  input  logic [1:0]        pll_lock,
  output logic [15:0]       mode_o,
  output logic [15:0]       strobe_o,
  output logic [15:0]       strobe_n_o
);
  localparam int SYNC_W = 10;

  // synchronized inputs: [4:0] serial, [6:5] cfg, [7] ready, [9:8] lock
  logic [SYNC_W-1:0] raw_in, sync_q;
  assign raw_in = {pll_lock, rx_ready, cfg_done, serial_pins};

  ctlbank_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q)
  );

  logic ready_s;
  assign ready_s = sync_q[7];

  logic in_win;
  sel_e sel;

  ctlbank_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(host_addr), .in_win(in_win), .sel(sel)
  );

  logic accept, wr_go, rd_go;
  assign accept = host_req && in_win;
  assign wr_go  = accept && host_we;
  assign rd_go  = accept && !host_we;

  // mode word with gated clock-select
  logic [15:0] mode_q, mode_nxt;
  always_comb begin
    mode_nxt = host_wdata & MODE_MASK;
    mode_nxt[CLKSEL_BIT] = host_wdata[CLKSEL_BIT] & (ready_s | mode_q[CLKSEL_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mode_q <= {11'b0, geo_addr, 1'b0};
    else if (wr_go && sel == SEL_MODE)   mode_q <= mode_nxt;
  end
  assign mode_o = mode_q;

  ctlbank_pulse #(.W(16), .MASK(PULSE_MASK)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .fire(wr_go && sel == SEL_PULSE),
    .wdata(host_wdata),
    .strobe(strobe_o), .strobe_n(strobe_n_o)
  );

  // read mux
  logic [15:0] rd_mux;
  always_comb begin
    unique case (sel)
      SEL_ID:   rd_mux = {SN_HI, sync_q[4:0], FW_ID};
      SEL_REV:  rd_mux = {FW_REV, HW_REV};
      SEL_MODE: rd_mux = mode_q;
      SEL_STAT: rd_mux = {6'b0, sync_q[9:5], 5'b0};
      default:  rd_mux = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_ack   <= 1'b0;
      host_rdata <= 16'h0000;
    end else begin
      host_ack <= accept;
      if (rd_go) host_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ctlbank_chk.sv
module ctlbank_chk #(
  parameter int                ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE   = 24'h700000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_req,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_ack,
  input logic [15:0]       host_rdata,
  input logic              rx_ready,
  input logic [15:0]       mode_o,
  input logic [15:0]       strobe_o
);
  logic page_hit;
  assign page_hit = (host_addr[ADDR_W-1:8] == BASE[ADDR_W-1:8]);

  // R2
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && page_hit |=> host_ack);

  // R2
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> $past(host_req));

  // R7
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o != 16'h0) |-> $past(host_req && host_we));

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o != 16'h0) && !host_req |=> (strobe_o == 16'h0));

  // R8
  pulse_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !host_we && page_hit && host_addr[7:1] == 7'd3 |=> host_rdata == 16'h0);

  // R5
  clksel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_o[5]) |-> $past(rx_ready, 3));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_we) |=> $stable(host_rdata));
endmodule

bind ctlbank_top ctlbank_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_addr(host_addr), .host_ack(host_ack), .host_rdata(host_rdata),
  .rx_ready(rx_ready), .mode_o(mode_o), .strobe_o(strobe_o)
);

// File: tb/tb_ctlbank_top.sv
`timescale 1ns/1ps
module tb_ctlbank_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, host_req, host_we, host_ack, rx_ready;
  logic [23:0] host_addr;
  logic [15:0] host_wdata, host_rdata, mode_o, strobe_o, strobe_n_o;
  logic [3:0]  geo_addr;
  logic [4:0]  serial_pins;
  logic [1:0]  cfg_done, pll_lock;

  ctlbank_top dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .geo_addr(geo_addr), .serial_pins(serial_pins),
    .cfg_done(cfg_done), .rx_ready(rx_ready), .pll_lock(pll_lock),
    .mode_o(mode_o), .strobe_o(strobe_o), .strobe_n_o(strobe_n_o)
  );

  localparam logic [23:0] BASE   = 24'h700000;
  localparam logic [15:0] M_MASK = 16'h3E7E;
  localparam logic [15:0] P_MASK = 16'h0F7F;

  int total = 0, failed = 0;
  bit done = 0;
  logic [15:0] m_mode;
  logic        cap_ack;
  logic [15:0] cap_rd, cap_st, cap_stn;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [23:0] a, input logic we, input logic [15:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    cap_ack = host_ack; cap_rd = host_rdata; cap_st = strobe_o; cap_stn = strobe_n_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_read(input logic [7:0] off);
    case (off)
      8'h00:   return {3'b101, serial_pins, 8'h5C};
      8'h02:   return 16'h1102;
      8'h04:   return m_mode;
      8'h08:   return {6'b0, pll_lock, rx_ready, cfg_done, 5'b0};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic mode_write(input logic [15:0] w, input string req);
    logic [15:0] nm;
    nm = w & M_MASK;
    nm[5] = w[5] & (rx_ready | m_mode[5]);
    m_mode = nm;
    access(BASE | 24'h04, 1'b1, w);
    access(BASE | 24'h04, 1'b0, 16'h0);
    check(req, cap_rd, m_mode);
    check(req, mode_o, m_mode);
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] pats [5] = '{16'hFFFF, 16'h0000, 16'hA5A5, 16'h5A5A, 16'h0020};
    logic [15:0] held;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    geo_addr = 4'hA; serial_pins = 5'h13; cfg_done = 2'b00; rx_ready = 1'b0; pll_lock = 2'b00;
    idle(4);
    // R1 reset state
    check("R1 mode", mode_o, 16'h0014);
    check("R1 strobe", strobe_o, 16'h0);
    check("R1 ack", {15'b0, host_ack}, 16'h0);
    m_mode = 16'h0014;
    rst_n = 1'b1;
    geo_addr = 4'h3;                      // R6 later pin change ignored
    cfg_done = 2'b01; pll_lock = 2'b10;
    idle(4);
    check("R6 pins after reset", mode_o, 16'h0014);
    check("R1 strobe_n", strobe_n_o, 16'hFFFF);

    // R2/R3 sweep all even offsets
    for (int o = 0; o < 256; o += 2) begin
      access(BASE | 24'(o), 1'b0, 16'h0);
      check("R2 ack in window", {15'b0, cap_ack}, 16'h1);
      check("R3 read map", cap_rd, exp_read(8'(o)));
    end
    // R2 outside window
    access(24'h710004, 1'b0, 16'h0);
    check("R2 no ack above", {15'b0, cap_ack}, 16'h0);
    access(24'h6F0004, 1'b1, 16'hFFFF);
    check("R2 no ack below", {15'b0, cap_ack}, 16'h0);
    check("R10 foreign write", mode_o, m_mode);

    // R4/R5 mode writes with receiver not ready
    for (int i = 0; i < 5; i++) mode_write(pats[i], "R4 R5 pattern");
    for (int i = 0; i < 16; i++) mode_write(16'h1 << i, "R4 single bit");
    mode_write(16'h001E, "R6 bypass writable");
    rx_ready = 1'b1; idle(4);
    mode_write(16'h0020, "R5 set when ready");
    rx_ready = 1'b0; idle(4);
    mode_write(16'hFFFF, "R5 keep set");
    mode_write(16'h0000, "R5 clear");
    mode_write(16'h0020, "R5 refused");

    // R7/R8/R9 pulse word
    for (int i = 0; i < 16; i++) begin
      access(BASE | 24'h06, 1'b1, 16'h1 << i);
      check("R7 strobe", cap_st, (16'h1 << i) & P_MASK);
      check("R9 inverse", cap_stn, ~((16'h1 << i) & P_MASK));
      @(negedge clk);
      check("R7 one cycle", strobe_o, 16'h0);
      access(BASE | 24'h06, 1'b0, 16'h0);
      check("R8 pulse reads zero", cap_rd, 16'h0);
    end
    access(BASE | 24'h06, 1'b1, 16'h0A00);
    check("R7 clear-errors and counter-reset", cap_st, 16'h0A00);
    access(BASE | 24'h06, 1'b1, 16'h0000);
    check("R7 zero write", cap_st, 16'h0);

    // R10 writes to read-only and undecoded words
    access(BASE | 24'h00, 1'b1, 16'h0000);
    access(BASE | 24'h02, 1'b1, 16'h0000);
    access(BASE | 24'h08, 1'b1, 16'hFFFF);
    access(BASE | 24'h40, 1'b1, 16'hFFFF);
    for (int o = 0; o < 10; o += 2) begin
      access(BASE | 24'(o), 1'b0, 16'h0);
      check("R10 unchanged", cap_rd, exp_read(8'(o)));
    end
    access(BASE | 24'h40, 1'b0, 16'h0);
    check("R10 undecoded", cap_rd, 16'h0);

    // R11 status follows inputs
    cfg_done = 2'b10; pll_lock = 2'b01; rx_ready = 1'b1; serial_pins = 5'h0C;
    idle(3);
    access(BASE | 24'h08, 1'b0, 16'h0);
    check("R11 status", cap_rd, 16'h01C0);
    access(BASE | 24'h00, 1'b0, 16'h0);
    check("R11 identity", cap_rd, 16'hAC5C);

    // R12 rdata holds across writes
    held = cap_rd;
    access(BASE | 24'h06, 1'b1, 16'h0001);
    check("R12 hold on write", cap_rd, held);
    idle(2);
    check("R12 hold idle", host_rdata, held);

    done = 1;
    finish_run();
  end
endmodule